// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the clocked front end of a small on-chip RAM of 36-bit words, organised as four 9-bit lanes. On every rising clock edge it reads two address strobes, three chip-enable inputs, a burst-advance input and the write controls. From these it forms one cycle kind: deselect, begin-burst, continue-burst or suspend-burst. A begin-burst loads an external address. Continue and suspend cycles step the low address bits through a four-beat burst or hold them. A separate sequencer inside the block produces the low address bits in either linear or interleaved order.

The two strobes behave differently. The priority strobe only counts while the first enable is asserted, and it always starts a read. The secondary strobe starts a read or a write, chosen by the write controls. A write can store every lane, or only the lanes picked by per-lane enables.

Read data reaches the output in one of two ways, chosen by a mode input:
- Flow-through: the output follows the array, so data appears after the addressing edge.
- Pipelined: the data passes through one output register first.

The output enable acts at once, without waiting for a clock edge. A sleep input blocks all cycles and keeps the stored contents.

Top module: `sbsram_ctrl`

## Requirements
- R1: The block is enabled only while en1_n=0, en2=1 and en3_n=0. A cycle start (pri_n=0 with en1_n=0, or sec_n=0) made while it is not enabled is a deselect. A deselect ends the burst, and later continue cycles neither read nor write until a new begin-burst.
- R2: A start with pri_n=0 and en1_n=0 while enabled is a read, whatever gw_n, bw_n and lane_n are.
- R3: While en1_n=1, pri_n has no effect. With sec_n=1 the cycle is a continue (adv_n=0) or suspend (adv_n=1) of the current burst.
- R4: Write-mask rules, where lane i is bits [9i+8:9i]:
  - gw_n=0 writes all lanes.
  - With gw_n=1 and bw_n=0, exactly the lanes with lane_n[i]=0 are written.
  - With bw_n=1, or with lane_n=4'b1111, the cycle is a read.
- R5: adv_n=0 in a continue cycle moves to the next burst address, wrapping after four beats. With order_lin=1 the offset is start+n mod 4; with order_lin=0 it is start XOR n. The order is taken when the burst begins.
- R6: adv_n=1 in a continue cycle (suspend) keeps the current address.
- R7: With pipe_mode=0, read data and dout_en=1 are valid after the addressing edge. With pipe_mode=1 they are valid one edge later.
- R8: After a write cycle, dout_en is 0. During a read, all 36 bits are driven, whatever lane_n is.
- R9: oe_n=1 forces dout_en to 0 at once. oe_n=0 only lets through a drive that is already due.
- R10: While sleep=1, dout_en is 0 and every cycle is ignored, including writes. The array keeps its contents, and decoding resumes on the first edge after sleep falls.
- R11: With pipe_mode=1, a read that was addressed on the edge before a deselect still reaches the output. dout_en drops one edge after the deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pipe_mode | input | 1 | 1 = registered read path, 0 = flow-through |
| order_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| sleep | input | 1 | Low-power hold, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| en1_n | input | 1 | Chip enable, active low; also gates pri_n |
| en2 | input | 1 | Chip enable, active high |
| en3_n | input | 1 | Chip enable, active low |
| pri_n | input | 1 | Priority address strobe (read start), active low |
| sec_n | input | 1 | Secondary address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bw_n | input | 1 | Lane write enable, active low |
| lane_n | input | 4 | Per-lane write select, active low |
| addr | input | AW | Word address loaded on a burst start |
| wdata | input | 36 | Write data, sampled with its cycle |
| dout | output | 36 | Read data |
| dout_en | output | 1 | Output drive enable for all lanes |

## Verification
- Flow-through results are due on the same edge that addresses the word. The bench samples 2 ns after that edge.
- Pipelined results are due one edge later. The pipelined sequence therefore expects no drive after the first edge, data after the second, and the last read still present after the deselect edge.
- The output-enable and sleep effects need no clock edge. The bench checks them 1 ns after the input changes, between edges.
- The effect of an ignored write or continue is read back through a later burst over the same addresses.

// File: rtl/sbsram_pkg.sv
`timescale 1ns/1ps
package sbsram_pkg;

    localparam int LANES   = 4;
    localparam int LANE_W  = 9;
    localparam int WORD_W  = LANES * LANE_W;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        CYC_DESEL = 2'd0,
        CYC_BEGIN = 2'd1,
        CYC_CONT  = 2'd2,
        CYC_SUSP  = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        logic             pri_n;
        logic             sec_n;
        logic             adv_n;
        logic             en1_n;
        logic             en2;
        logic             en3_n;
        logic             gw_n;
        logic             bw_n;
        logic [LANES-1:0] lane_n;
    } ctrl_t;

    typedef struct packed {
        cyc_kind_e        kind;
        logic [LANES-1:0] wmask;
    } cyc_t;

    // spread a per-lane mask over the bits of a word
    function automatic logic [WORD_W-1:0] lane_bits(input logic [LANES-1:0] m);
        logic [WORD_W-1:0] r;
        for (int l = 0; l < LANES; l++) begin
            r[l*LANE_W +: LANE_W] = {LANE_W{m[l]}};
        end
        return r;
    endfunction

endpackage

// File: rtl/sbsram_cycle_decode.sv
`timescale 1ns/1ps
module sbsram_cycle_decode
    import sbsram_pkg::*;
(
    input  ctrl_t c,
    output cyc_t  cyc
);

    logic             start;
    logic             enabled;
    logic [LANES-1:0] ctl_mask;

    always_comb begin
        // the priority strobe is only seen while the first enable is active
        start   = (!c.pri_n && !c.en1_n) || !c.sec_n;
        enabled = !c.en1_n && c.en2 && !c.en3_n;

        if (!c.gw_n)      ctl_mask = '1;
        else if (!c.bw_n) ctl_mask = ~c.lane_n;
        else              ctl_mask = '0;

        if (!start)        cyc.kind = c.adv_n ? CYC_SUSP : CYC_CONT;
        else if (!enabled) cyc.kind = CYC_DESEL;
        else               cyc.kind = CYC_BEGIN;

        // a priority-strobe start is always a read
        if (cyc.kind == CYC_DESEL)                      cyc.wmask = '0;
        else if (cyc.kind == CYC_BEGIN && !c.pri_n)     cyc.wmask = '0;
        else                                            cyc.wmask = ctl_mask;
    end

endmodule

// File: rtl/sbsram_burst_seq.sv
`timescale 1ns/1ps
module sbsram_burst_seq #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         adv,
    input  logic         lin_in,
    input  logic [W-1:0] start_lo,
    output logic [W-1:0] lo_now,
    output logic [W-1:0] lo_next
);

    logic [W-1:0] base_q;
    logic [W-1:0] cnt_q;
    logic         lin_q;

    function automatic logic [W-1:0] offs(input logic [W-1:0] b,
                                          input logic [W-1:0] n,
                                          input logic         lin);
        return lin ? W'(b + n) : (b ^ n);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
            lin_q  <= 1'b1;
        end else if (load) begin
            base_q <= start_lo;
            cnt_q  <= '0;
            lin_q  <= lin_in;
        end else if (adv) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign lo_now  = offs(base_q, cnt_q, lin_q);
    assign lo_next = offs(base_q, cnt_q + 1'b1, lin_q);

    // R5: every advance lands on a different offset
    p_adv_moves_r5: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |=> (lo_now != $past(lo_now)));

    // R6: without load or advance the offset is held
    p_susp_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load) |=> $stable(lo_now));

endmodule

// File: rtl/sbsram_out_stage.sv
`timescale 1ns/1ps
module sbsram_out_stage
    import sbsram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              pipe_mode,
    input  logic              oe_n,
    input  logic              rd_act,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);

    logic              pipe_vld;
    logic [WORD_W-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_vld <= 1'b0;
            pipe_q   <= '0;
        end else if (sleep) begin
            pipe_vld <= 1'b0;
        end else begin
            pipe_vld <= rd_act;
            pipe_q   <= rd_word;
        end
    end

    always_comb begin
        dout    = pipe_mode ? pipe_q : rd_word;
        dout_en = !oe_n && !sleep && (pipe_mode ? pipe_vld : rd_act);
    end

    // R11: a pipelined read in flight still reaches the output next cycle
    p_pipe_drains_r11: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && rd_act && !sleep) |=> (!pipe_mode || sleep || oe_n || dout_en));

    // R9: a high output enable never lets a drive through
    p_oe_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dout_en);

endmodule

// File: rtl/sbsram_ctrl.sv
`timescale 1ns/1ps
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pipe_mode,
    input  logic              order_lin,
    input  logic              sleep,
    input  logic              oe_n,
    input  logic              en1_n,
    input  logic              en2,
    input  logic              en3_n,
    input  logic              pri_n,
    input  logic              sec_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bw_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);

    localparam int DEPTH = 1 << AW;
    localparam int HI_W  = AW - BURST_W;

    ctrl_t             ctl;
    cyc_t              cyc;
    logic              active;
    logic              rd_act;
    logic [HI_W-1:0]   hi_q;
    logic [BURST_W-1:0] lo_now;
    logic [BURST_W-1:0] lo_next;
    logic [AW-1:0]     cur_addr;
    logic [AW-1:0]     cyc_addr;
    logic              do_load;
    logic              do_adv;
    logic              do_keep;
    logic              we;
    logic [WORD_W-1:0] wbits;
    logic [WORD_W-1:0] mem [DEPTH];

    always_comb begin
        ctl.pri_n  = pri_n;
        ctl.sec_n  = sec_n;
        ctl.adv_n  = adv_n;
        ctl.en1_n  = en1_n;
        ctl.en2    = en2;
        ctl.en3_n  = en3_n;
        ctl.gw_n   = gw_n;
        ctl.bw_n   = bw_n;
        ctl.lane_n = lane_n;
    end

    sbsram_cycle_decode u_dec (
        .c   (ctl),
        .cyc (cyc)
    );

    always_comb begin
        do_load  = !sleep && (cyc.kind == CYC_BEGIN);
        do_adv   = !sleep && active && (cyc.kind == CYC_CONT);
        do_keep  = !sleep && active && (cyc.kind == CYC_SUSP);
        we       = (do_load || do_adv || do_keep) && (|cyc.wmask);
        wbits    = lane_bits(cyc.wmask);
        cur_addr = {hi_q, lo_now};
        if (do_load)     cyc_addr = addr;
        else if (do_adv) cyc_addr = {hi_q, lo_next};
        else             cyc_addr = cur_addr;
    end

    sbsram_burst_seq #(.W(BURST_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .load     (do_load),
        .adv      (do_adv),
        .lin_in   (order_lin),
        .start_lo (addr[BURST_W-1:0]),
        .lo_now   (lo_now),
        .lo_next  (lo_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            rd_act <= 1'b0;
            hi_q   <= '0;
        end else if (sleep || cyc.kind == CYC_DESEL) begin
            active <= 1'b0;
            rd_act <= 1'b0;
        end else if (do_load) begin
            active <= 1'b1;
            hi_q   <= addr[AW-1:BURST_W];
            rd_act <= ~|cyc.wmask;
        end else if (active) begin
            rd_act <= ~|cyc.wmask;
        end else begin
            rd_act <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[cyc_addr] <= (mem[cyc_addr] & ~wbits) | (wdata & wbits);
        end
    end

    sbsram_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .sleep     (sleep),
        .pipe_mode (pipe_mode),
        .oe_n      (oe_n),
        .rd_act    (rd_act),
        .rd_word   (mem[cur_addr]),
        .dout      (dout),
        .dout_en   (dout_en)
    );

    // R2: a priority-strobe start never stores anything
    p_pri_reads_r2: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !pri_n && !en1_n) |-> !we);

    // R10: no store happens while asleep
    p_sleep_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !we);

    // R1: a start with a false enable closes the burst
    p_desel_ends_r1: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !sec_n && (en1_n || !en2 || en3_n)) |=> !active);

    // R4: a store with global write off needs the lane write enable
    p_lane_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (we && gw_n) |-> !bw_n);

    // R8: after a store the flow-through output is not driven
    p_write_hiz_r8: assert property (@(posedge clk) disable iff (rst)
        (we && !pipe_mode) |=> (pipe_mode || !dout_en));

endmodule

// File: tb/sbsram_ctrl_tb_top.sv
`timescale 1ns/1ps
module sbsram_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        pipe_mode, order_lin, sleep, oe_n;
    logic        en1_n, en2, en3_n, pri_n, sec_n, adv_n, gw_n, bw_n;
    logic [3:0]  lane_n;
    logic [5:0]  addr;
    logic [35:0] wdata;
    logic [35:0] dout;
    logic        dout_en;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sbsram_ctrl #(.AW(6)) dut_i (
        .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .order_lin(order_lin),
        .sleep(sleep), .oe_n(oe_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
        .pri_n(pri_n), .sec_n(sec_n), .adv_n(adv_n), .gw_n(gw_n), .bw_n(bw_n),
        .lane_n(lane_n), .addr(addr), .wdata(wdata), .dout(dout), .dout_en(dout_en)
    );

    localparam logic [35:0] W0 = 36'h1_2345_6789;
    localparam logic [35:0] W1 = 36'h2_468A_CE02;
    localparam logic [35:0] W2 = 36'h9_8765_4321;
    localparam logic [35:0] W3 = 36'h5_A5A5_A5A5;
    localparam logic [35:0] LM = {9'h1FF, 9'h000, 9'h1FF, 9'h000};
    localparam logic [35:0] WM = W0 | LM;

    typedef struct packed {
        logic [7:0]  c;      // pri sec adv en1 en2 en3 gw bw
        logic [3:0]  lane;
        logic [5:0]  a;
        logic [35:0] wd;
        logic        exp_en;
        logic [35:0] exp_d;
        logic [4:0]  req;
    } vec_t;

    function automatic vec_t mk(input logic [7:0] c, input logic [3:0] lane,
                                input logic [5:0] a, input logic [35:0] wd,
                                input logic e, input logic [35:0] d, input logic [4:0] r);
        vec_t v;
        v.c = c; v.lane = lane; v.a = a; v.wd = wd;
        v.exp_en = e; v.exp_d = d; v.req = r;
        return v;
    endfunction

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        mk(8'b1010_1001, 4'hF, 6'd4, W0, 1'b0, 36'h0, 5'd4),   // R4 global write @4
        mk(8'b1100_1001, 4'hF, 6'd0, W1, 1'b0, 36'h0, 5'd8),   // R8 write hides output @5
        mk(8'b1100_1001, 4'hF, 6'd0, W2, 1'b0, 36'h0, 5'd8),   // @6
        mk(8'b1100_1001, 4'hF, 6'd0, W3, 1'b0, 36'h0, 5'd8),   // @7
        mk(8'b0110_1000, 4'h0, 6'd6, 36'h0, 1'b1, W2, 5'd2),   // R2 pri start reads despite writes
        mk(8'b1100_1011, 4'hF, 6'd0, 36'h0, 1'b1, W3, 5'd5),   // R5 linear 6->7
        mk(8'b1110_1011, 4'hF, 6'd0, 36'h0, 1'b1, W3, 5'd6),   // R6 suspend
        mk(8'b1100_1011, 4'hF, 6'd0, 36'h0, 1'b1, W0, 5'd5),   // R5 7->4
        mk(8'b1100_1011, 4'hF, 6'd0, 36'h0, 1'b1, W1, 5'd5),   // R5 4->5
        mk(8'b1100_1011, 4'hF, 6'd0, 36'h0, 1'b1, W2, 5'd5),   // R5 wrap back to 6
        mk(8'b1010_1010, 4'hF, 6'd5, 36'h0, 1'b1, W1, 5'd4),   // R4 no lane picked = read
        mk(8'b1010_1010, 4'b0101, 6'd4, 36'hF_FFFF_FFFF, 1'b0, 36'h0, 5'd4), // R4 lanes 1,3
        mk(8'b0110_1011, 4'hF, 6'd4, 36'h0, 1'b1, WM, 5'd4),   // R4 merged word, R8 all lanes
        mk(8'b0111_1011, 4'hF, 6'd7, 36'h0, 1'b1, WM, 5'd3),   // R3 pri ignored with en1_n=1
        mk(8'b1010_0011, 4'hF, 6'd4, 36'h0, 1'b0, 36'h0, 5'd1),// R1 deselect
        mk(8'b1100_1001, 4'hF, 6'd0, 36'h0, 1'b0, 36'h0, 5'd1) // R1 continue after deselect does nothing
    };

    task automatic drive(input logic [7:0] c, input logic [3:0] lane,
                         input logic [5:0] a, input logic [35:0] wd);
        {pri_n, sec_n, adv_n, en1_n, en2, en3_n, gw_n, bw_n} = c;
        lane_n = lane; addr = a; wdata = wd;
    endtask

    task automatic chk_en(input string r, input logic exp);
        checks++;
        if (dout_en !== exp) begin
            errors++;
            $display("FAIL %s dout_en actual %b expected %b", r, dout_en, exp);
        end
    endtask

    task automatic chk_d(input string r, input logic [35:0] exp);
        checks++;
        if (dout !== exp) begin
            errors++;
            $display("FAIL %s dout actual %h expected %h", r, dout, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #2;
    endtask

    localparam logic [7:0] IDLE = 8'b1110_1011;

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; pipe_mode = 1'b0; order_lin = 1'b1; sleep = 1'b0; oe_n = 1'b0;
        drive(IDLE, 4'hF, 6'd0, 36'h0);
        repeat (3) step();
        chk_en("reset", 1'b0);
        rst = 1'b0;
        step();
        chk_en("reset", 1'b0);

        // table walk, flow-through, linear order
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].c, VECS[i].lane, VECS[i].a, VECS[i].wd);
            step();
            checks++;
            if (dout_en !== VECS[i].exp_en) begin
                errors++;
                $display("FAIL R%0d vec %0d dout_en actual %b expected %b",
                         VECS[i].req, i, dout_en, VECS[i].exp_en);
            end
            if (VECS[i].exp_en) begin
                checks++;
                if (dout !== VECS[i].exp_d) begin
                    errors++;
                    $display("FAIL R%0d vec %0d dout actual %h expected %h",
                             VECS[i].req, i, dout, VECS[i].exp_d);
                end
            end
        end

        // R7 / R11: pipelined read path with single-cycle deselect
        pipe_mode = 1'b1;
        drive(8'b0110_1011, 4'hF, 6'd6, 36'h0);
        step();
        chk_en("R7 pipe first edge", 1'b0);
        drive(8'b1100_1011, 4'hF, 6'd0, 36'h0);
        step();
        chk_en("R7 pipe data due", 1'b1);
        chk_d("R7 pipe data", W2);
        drive(8'b1010_1111, 4'hF, 6'd0, 36'h0);
        step();
        chk_en("R11 last read drains", 1'b1);
        chk_d("R11 last read data", W3);
        drive(IDLE, 4'hF, 6'd0, 36'h0);
        step();
        chk_en("R11 off after deselect", 1'b0);

        // R5: interleaved order from offset 1: 5,4,7,6
        pipe_mode = 1'b0; order_lin = 1'b0;
        drive(8'b0110_1011, 4'hF, 6'd5, 36'h0);
        step();
        chk_d("R5 ilv beat0", W1);
        drive(8'b1100_1011, 4'hF, 6'd0, 36'h0);
        step();
        chk_d("R5 ilv beat1", WM);
        step();
        chk_d("R5 ilv beat2", W3);
        step();
        chk_d("R5 ilv beat3", W2);
        chk_en("R5 ilv drive", 1'b1);

        // R9: asynchronous output enable between edges
        drive(IDLE, 4'hF, 6'd0, 36'h0);
        #3 oe_n = 1'b1;
        #1 chk_en("R9 oe off", 1'b0);
        oe_n = 1'b0;
        #1 chk_en("R9 oe back", 1'b1);

        // R10: sleep hides output, ignores a write, keeps contents
        sleep = 1'b1;
        #1 chk_en("R10 sleep hiz", 1'b0);
        drive(8'b1010_1001, 4'hF, 6'd6, 36'h0);
        step();
        chk_en("R10 asleep", 1'b0);
        sleep = 1'b0;
        drive(8'b0110_1011, 4'hF, 6'd6, 36'h0);
        step();
        chk_en("R10 wake read", 1'b1);
        chk_d("R10 retained", W2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule